// File: doc/BRIEF.md
# SDRAM Bank Timing Tracker

This block watches the command stream that a memory controller sends to a four-bank SDRAM. It keeps, for every bank, whether a row is open and how many cycles remain on each timing constraint. From that state it tells the controller, for each bank and each kind of command, whether the command would be legal in the current cycle. The controller's arbiter reads these flags and picks a command. Choosing between commands and moving data are not part of this block.

Each constraint is a down-counter. The counter is loaded when the command that starts the constraint is observed, and the command it guards becomes legal once the counter reads zero. Together the counters cover row-to-column delay, spacing between activates, minimum and maximum row open time, precharge time and write recovery. An auto-precharge access locks its bank until the burst has finished and the bank has closed by itself. A command that makes no sense for the bank's state raises a one-cycle error flag and leaves the state unchanged.

Top module: `sdram_bank_guard`

## Requirements
- R1: Command codes on `cmd_op` are 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 burst stop; a command counts only when `cmd_valid` is high. After reset every bank is idle: `bank_open`, `col_ok`, `pre_ok`, `ras_overdue` and `cmd_illegal` are all zero and `act_ok` is all ones.
- R2: After an activate to bank b in cycle k, `col_ok[b]` is low until cycle k+T_RCD and high from then on while the row stays open.
- R3: After an accepted activate in cycle k, `act_ok` is low for every bank until cycle k+T_RRD.
- R4: After an activate to bank b in cycle k, `pre_ok[b]` stays low until at least cycle k+T_RAS_MIN.
- R5: `ras_overdue[b]` goes high in cycle k+T_RAS_MAX when bank b was activated in cycle k and is still open, and drops once the bank is closed.
- R6: A precharge to open bank b in cycle p closes it in cycle p+1, and `act_ok[b]` stays low until cycle p+T_RP.
- R7: After a write to bank b in cycle w, `pre_ok[b]` stays low until cycle w+BURST_LEN-1+T_RDL, the last data beat plus the write recovery time.
- R8: A burst stop in cycle s shortens any pending write recovery so that precharge is allowed from cycle s-1+T_RDL.
- R9: A read or write with `cmd_a10` high (auto precharge) to bank b in cycle k clears `col_ok[b]` and `pre_ok[b]` from cycle k+1 and ignores burst stop. The bank closes by itself in the first cycle after k+BURST_LEN-1 in which the write recovery and minimum open time are also met, and `act_ok[b]` rises T_RP cycles after that closing.
- R10: `cmd_bank` selects the bank: 00 is bit 0, 01 bit 1, 10 bit 2, 11 bit 3 of every per-bank output. A precharge with `cmd_a10` high closes every open bank whatever `cmd_bank` holds.
- R11: A read or write to an idle bank, or an activate to an open bank, sets `cmd_illegal` in the next cycle for one cycle and changes no bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_bank | input | 2 | Target bank (see R10) |
| cmd_a10 | input | 1 | Auto precharge on read/write, all banks on precharge |
| bank_open | output | 4 | Row open per bank |
| act_ok | output | 4 | Activate allowed per bank |
| col_ok | output | 4 | Read or write allowed per bank |
| pre_ok | output | 4 | Precharge allowed per bank |
| ras_overdue | output | 4 | Row held open past the maximum open time |
| cmd_illegal | output | 1 | Previous command did not fit the bank state |

## Verification
The assertions take for granted that at most one command arrives per cycle and that every timing parameter is at least one; a property that only makes sense for a delay above one cycle is generated only when that parameter is above one. They also expect an activate, precharge or auto-precharge access to be judged against the flags that stood in the cycle of issue, so they fire only when the matching allowed flag was high. The stimulus drives each command for exactly one cycle from a single task, returns the bus to the no-command code at once, and waits for the allowed flag before every command except the deliberately illegal ones.

// File: rtl/bank_guard_pkg.sv
`timescale 1ns/1ps
package bank_guard_pkg;

    // command codes on the observed command bus
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_STOP = 3'd5
    } bg_op_e;

    localparam int BG_OP_W = 3;

endpackage

// File: rtl/bank_guard_decode.sv
`timescale 1ns/1ps
// Turns one observed command into per-bank strobes.
module bank_guard_decode
    import bank_guard_pkg::*;
#(
    parameter int BANK_W = 2,
    localparam int NB = 1 << BANK_W
) (
    input  logic               cmd_valid,
    input  logic [BG_OP_W-1:0] cmd_op,
    input  logic [BANK_W-1:0]  cmd_bank,
    input  logic               cmd_a10,
    output logic [NB-1:0]      act_hit,
    output logic [NB-1:0]      rd_hit,
    output logic [NB-1:0]      wr_hit,
    output logic [NB-1:0]      pre_hit,
    output logic               stop_hit,
    output logic               auto_pc
);

    logic [NB-1:0] sel;

    always_comb begin
        sel      = NB'(1) << cmd_bank;
        act_hit  = '0;
        rd_hit   = '0;
        wr_hit   = '0;
        pre_hit  = '0;
        stop_hit = 1'b0;
        auto_pc  = cmd_a10;
        if (cmd_valid) begin
            if (cmd_op == OP_ACT) act_hit = sel;
            if (cmd_op == OP_RD)  rd_hit  = sel;
            if (cmd_op == OP_WR)  wr_hit  = sel;
            if (cmd_op == OP_PRE) pre_hit = cmd_a10 ? '1 : sel;
            if (cmd_op == OP_STOP) stop_hit = 1'b1;
        end
    end

endmodule

// File: rtl/bank_guard_spacing.sv
`timescale 1ns/1ps
// Activate-to-activate spacing shared by all banks.
module bank_guard_spacing #(
    parameter int T_RRD = 3,
    localparam int CW = $clog2(T_RRD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_taken,
    output logic clear
);

    localparam logic [CW-1:0] L_RRD = CW'(T_RRD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } sp_st_t;

    sp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (act_taken)
            st_d.cnt = L_RRD;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clear = (st_q.cnt == '0);

endmodule

// File: rtl/bank_guard_bank.sv
`timescale 1ns/1ps
// State and timers of one bank.
module bank_guard_bank #(
    parameter int T_RCD     = 4,
    parameter int T_RP      = 4,
    parameter int T_RAS_MIN = 10,
    parameter int T_RAS_MAX = 25000,
    parameter int T_RDL     = 2,
    parameter int BURST_LEN = 4,
    parameter int CW        = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_hit,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic pre_hit,
    input  logic stop_hit,
    input  logic auto_pc,
    output logic open_o,
    output logic act_rdy_o,
    output logic col_rdy_o,
    output logic pre_rdy_o,
    output logic overdue_o
);

    localparam logic [CW-1:0] L_RCD    = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_RP     = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_RASMIN = CW'(T_RAS_MIN - 1);
    localparam logic [CW-1:0] L_RASMAX = CW'(T_RAS_MAX - 1);
    localparam logic [CW-1:0] L_WREC   = CW'(BURST_LEN + T_RDL - 2);
    localparam logic [CW-1:0] L_STOP   = CW'(T_RDL - 2);
    localparam logic [CW-1:0] L_BURST  = CW'(BURST_LEN - 1);

    typedef struct packed {
        logic          open;
        logic          ap_pend;
        logic [CW-1:0] rcd;
        logic [CW-1:0] ras_min;
        logic [CW-1:0] ras_max;
        logic [CW-1:0] rp;
        logic [CW-1:0] wrec;
        logic [CW-1:0] burst;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     ap_done;

    function automatic logic [CW-1:0] tick(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        st_d         = st_q;
        st_d.rcd     = tick(st_q.rcd);
        st_d.ras_min = tick(st_q.ras_min);
        st_d.ras_max = tick(st_q.ras_max);
        st_d.rp      = tick(st_q.rp);
        st_d.wrec    = tick(st_q.wrec);
        st_d.burst   = tick(st_q.burst);

        // internal close once the locked burst, recovery and open time are done
        ap_done = st_q.open && st_q.ap_pend && (st_q.burst == '0)
                  && (st_q.wrec == '0) && (st_q.ras_min == '0);

        if (ap_done) begin
            st_d.open    = 1'b0;
            st_d.ap_pend = 1'b0;
            st_d.rp      = L_RP;
        end else if (act_hit && !st_q.open) begin
            st_d.open    = 1'b1;
            st_d.rcd     = L_RCD;
            st_d.ras_min = L_RASMIN;
            st_d.ras_max = L_RASMAX;
            st_d.wrec    = '0;
            st_d.burst   = '0;
        end else if ((rd_hit || wr_hit) && st_q.open && !st_q.ap_pend) begin
            if (wr_hit)
                st_d.wrec = L_WREC;
            if (auto_pc) begin
                st_d.ap_pend = 1'b1;
                st_d.burst   = L_BURST;
            end
        end else if (pre_hit && st_q.open && !st_q.ap_pend) begin
            st_d.open = 1'b0;
            st_d.rp   = L_RP;
            st_d.wrec = '0;
        end else if (stop_hit && !st_q.ap_pend && (st_q.wrec > L_STOP)) begin
            st_d.wrec = L_STOP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o    = st_q.open;
    assign act_rdy_o = !st_q.open && (st_q.rp == '0);
    assign col_rdy_o = st_q.open && !st_q.ap_pend && (st_q.rcd == '0);
    assign pre_rdy_o = st_q.open && !st_q.ap_pend && (st_q.ras_min == '0)
                       && (st_q.wrec == '0);
    assign overdue_o = st_q.open && (st_q.ras_max == '0);

endmodule

// File: rtl/sdram_bank_guard.sv
`timescale 1ns/1ps
// Per-bank SDRAM timing tracker: observes commands, reports what is legal.
module sdram_bank_guard
    import bank_guard_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int T_RCD     = 4,
    parameter int T_RRD     = 3,
    parameter int T_RP      = 4,
    parameter int T_RAS_MIN = 10,
    parameter int T_RAS_MAX = 25000,
    parameter int T_RDL     = 2,
    parameter int BURST_LEN = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd_op,
    input  logic [BANK_W-1:0]          cmd_bank,
    input  logic                       cmd_a10,
    output logic [(1 << BANK_W)-1:0]   bank_open,
    output logic [(1 << BANK_W)-1:0]   act_ok,
    output logic [(1 << BANK_W)-1:0]   col_ok,
    output logic [(1 << BANK_W)-1:0]   pre_ok,
    output logic [(1 << BANK_W)-1:0]   ras_overdue,
    output logic                       cmd_illegal
);

    localparam int NB    = 1 << BANK_W;
    localparam int T_SUM = T_RAS_MAX + T_RAS_MIN + T_RCD + T_RP + BURST_LEN + T_RDL;
    localparam int CW    = $clog2(T_SUM + 1);

    typedef struct packed {
        logic illegal;
    } top_st_t;

    logic [NB-1:0] act_hit, rd_hit, wr_hit, pre_hit;
    logic [NB-1:0] act_rdy;
    logic          stop_hit, auto_pc, rrd_clear, act_taken;
    top_st_t       st_d, st_q;

    bank_guard_decode #(.BANK_W(BANK_W)) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank),
        .cmd_a10   (cmd_a10),
        .act_hit   (act_hit),
        .rd_hit    (rd_hit),
        .wr_hit    (wr_hit),
        .pre_hit   (pre_hit),
        .stop_hit  (stop_hit),
        .auto_pc   (auto_pc)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        bank_guard_bank #(
            .T_RCD     (T_RCD),
            .T_RP      (T_RP),
            .T_RAS_MIN (T_RAS_MIN),
            .T_RAS_MAX (T_RAS_MAX),
            .T_RDL     (T_RDL),
            .BURST_LEN (BURST_LEN),
            .CW        (CW)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_hit   (act_hit[b]),
            .rd_hit    (rd_hit[b]),
            .wr_hit    (wr_hit[b]),
            .pre_hit   (pre_hit[b]),
            .stop_hit  (stop_hit),
            .auto_pc   (auto_pc),
            .open_o    (bank_open[b]),
            .act_rdy_o (act_rdy[b]),
            .col_rdy_o (col_ok[b]),
            .pre_rdy_o (pre_ok[b]),
            .overdue_o (ras_overdue[b])
        );
    end

    // only activates that really open a row restart the spacing window
    assign act_taken = |(act_hit & ~bank_open);

    bank_guard_spacing #(.T_RRD(T_RRD)) u_spacing (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_taken (act_taken),
        .clear     (rrd_clear)
    );

    assign act_ok = act_rdy & {NB{rrd_clear}};

    always_comb begin
        st_d.illegal = (|(act_hit & bank_open)) | (|((rd_hit | wr_hit) & ~bank_open));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_illegal = st_q.illegal;

endmodule

// File: rtl/sdram_bank_guard_chk.sv
`timescale 1ns/1ps
module sdram_bank_guard_chk
    import bank_guard_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int T_RCD     = 4,
    parameter int T_RRD     = 3,
    parameter int T_RP      = 4,
    parameter int T_RAS_MIN = 10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_valid,
    input logic [2:0]               cmd_op,
    input logic [BANK_W-1:0]        cmd_bank,
    input logic                     cmd_a10,
    input logic [(1 << BANK_W)-1:0] bank_open,
    input logic [(1 << BANK_W)-1:0] act_ok,
    input logic [(1 << BANK_W)-1:0] col_ok,
    input logic [(1 << BANK_W)-1:0] pre_ok,
    input logic                     cmd_illegal
);

    localparam int NB = 1 << BANK_W;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank_open == '0 && !cmd_illegal));

    assert_bad_target_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR) && !bank_open[cmd_bank])
        |=> cmd_illegal);

    if (T_RRD > 1) begin : g_rrd
        assert_act_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == OP_ACT && act_ok[cmd_bank]) |=> (act_ok == '0));
    end

    for (genvar b = 0; b < NB; b++) begin : g_b
        if (T_RCD > 1) begin : g_rcd
            assert_col_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_valid && cmd_op == OP_ACT && cmd_bank == BANK_W'(b) && act_ok[b])
                |=> (bank_open[b] && !col_ok[b]));
        end
        if (T_RAS_MIN > 1) begin : g_ras
            assert_open_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_valid && cmd_op == OP_ACT && cmd_bank == BANK_W'(b) && act_ok[b])
                |=> !pre_ok[b]);
        end
        assert_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == OP_PRE && !cmd_a10 && cmd_bank == BANK_W'(b) && pre_ok[b])
            |=> !bank_open[b]);
        if (T_RP > 1) begin : g_rp
            assert_reopen_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_valid && cmd_op == OP_PRE && cmd_bank == BANK_W'(b) && pre_ok[b])
                |=> !act_ok[b]);
        end
        assert_auto_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR) && cmd_a10
             && cmd_bank == BANK_W'(b) && col_ok[b])
            |=> (!col_ok[b] && !pre_ok[b]));
    end

endmodule

bind sdram_bank_guard sdram_bank_guard_chk #(
    .BANK_W    (BANK_W),
    .T_RCD     (T_RCD),
    .T_RRD     (T_RRD),
    .T_RP      (T_RP),
    .T_RAS_MIN (T_RAS_MIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_bank    (cmd_bank),
    .cmd_a10     (cmd_a10),
    .bank_open   (bank_open),
    .act_ok      (act_ok),
    .col_ok      (col_ok),
    .pre_ok      (pre_ok),
    .cmd_illegal (cmd_illegal)
);

// File: tb/sdram_bank_guard_bench.sv
`timescale 1ns/1ps
module sdram_bank_guard_bench;
    import bank_guard_pkg::*;

    // timings used by this bench: RCD 3, RRD 2, RP 3, RAS min 6, RAS max 40, RDL 2, burst 4
    localparam int P_RCD = 3, P_RRD = 2, P_RP = 3, P_RASMIN = 6, P_RASMAX = 40;
    localparam int P_RDL = 2, P_BL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = OP_NONE;
    logic [1:0] cmd_bank = 2'd0;
    logic       cmd_a10 = 1'b0;
    logic [3:0] bank_open, act_ok, col_ok, pre_ok, ras_overdue;
    logic       cmd_illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sdram_bank_guard #(
        .BANK_W(2), .T_RCD(P_RCD), .T_RRD(P_RRD), .T_RP(P_RP),
        .T_RAS_MIN(P_RASMIN), .T_RAS_MAX(P_RASMAX), .T_RDL(P_RDL), .BURST_LEN(P_BL)
    ) u_sdram_bank_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .bank_open(bank_open),
        .act_ok(act_ok), .col_ok(col_ok), .pre_ok(pre_ok),
        .ras_overdue(ras_overdue), .cmd_illegal(cmd_illegal)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drives one command for one cycle; returns one cycle later
    task automatic issue(input logic [2:0] op, input logic [1:0] b, input logic a10);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_bank  = b;
        cmd_a10   = a10;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = OP_NONE;
        cmd_bank  = 2'd0;
        cmd_a10   = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", "bank_open", 32'(bank_open), 32'h0);
        check("R1", "act_ok", 32'(act_ok), 32'hF);
        check("R1", "col_ok", 32'(col_ok), 32'h0);
        check("R1", "pre_ok", 32'(pre_ok), 32'h0);
        check("R1", "ras_overdue", 32'(ras_overdue), 32'h0);
        check("R1", "cmd_illegal", 32'(cmd_illegal), 32'h0);
    endtask

    task automatic t_open_and_close;
        issue(OP_ACT, 2'd0, 1'b0);                        // j1
        check("R10", "bank A open", 32'(bank_open), 32'h1);
        check("R2", "col_ok j1", 32'(col_ok[0]), 32'h0);
        check("R3", "act_ok B j1", 32'(act_ok[1]), 32'h0);
        check("R11", "legal activate", 32'(cmd_illegal), 32'h0);
        step(1);                                           // j2
        check("R3", "act_ok B j2", 32'(act_ok[1]), 32'h1);
        check("R2", "col_ok j2", 32'(col_ok[0]), 32'h0);
        step(1);                                           // j3
        check("R2", "col_ok j3", 32'(col_ok[0]), 32'h1);
        check("R4", "pre_ok j3", 32'(pre_ok[0]), 32'h0);
        step(2);                                           // j5
        check("R4", "pre_ok j5", 32'(pre_ok[0]), 32'h0);
        step(1);                                           // j6
        check("R4", "pre_ok j6", 32'(pre_ok[0]), 32'h1);
        issue(OP_PRE, 2'd0, 1'b0);                         // p1
        check("R6", "closed p1", 32'(bank_open), 32'h0);
        check("R6", "act_ok p1", 32'(act_ok[0]), 32'h0);
        step(1);
        check("R6", "act_ok p2", 32'(act_ok[0]), 32'h0);
        step(1);
        check("R6", "act_ok p3", 32'(act_ok[0]), 32'h1);
        step(4);
    endtask

    task automatic t_write_recovery;
        issue(OP_ACT, 2'd1, 1'b0);
        step(2);                                           // j3
        issue(OP_WR, 2'd1, 1'b0);                          // w1
        check("R7", "pre_ok w1", 32'(pre_ok[1]), 32'h0);
        step(3);                                           // w4
        check("R7", "pre_ok w4", 32'(pre_ok[1]), 32'h0);
        step(1);                                           // w5
        check("R7", "pre_ok w5", 32'(pre_ok[1]), 32'h1);
        issue(OP_PRE, 2'd1, 1'b0);
        step(4);
    endtask

    task automatic t_burst_stop;
        issue(OP_ACT, 2'd2, 1'b0);
        step(5);                                           // j6
        issue(OP_WR, 2'd2, 1'b0);                          // k+1
        issue(OP_STOP, 2'd0, 1'b0);                        // k+2
        check("R8", "pre_ok after stop", 32'(pre_ok[2]), 32'h1);
        issue(OP_PRE, 2'd2, 1'b0);
        step(4);
    endtask

    task automatic t_auto_read;
        issue(OP_ACT, 2'd3, 1'b0);
        step(2);                                           // j3
        issue(OP_RD, 2'd3, 1'b1);                          // r1
        check("R9", "col_ok locked", 32'(col_ok[3]), 32'h0);
        check("R9", "pre_ok locked", 32'(pre_ok[3]), 32'h0);
        step(3);                                           // r4
        check("R9", "open r4", 32'(bank_open[3]), 32'h1);
        step(1);                                           // r5
        check("R9", "open r5", 32'(bank_open[3]), 32'h0);
        check("R9", "act_ok r5", 32'(act_ok[3]), 32'h0);
        step(1);
        check("R9", "act_ok r6", 32'(act_ok[3]), 32'h0);
        step(1);
        check("R9", "act_ok r7", 32'(act_ok[3]), 32'h1);
        step(4);
    endtask

    task automatic t_auto_write;
        issue(OP_ACT, 2'd0, 1'b0);
        step(2);
        issue(OP_WR, 2'd0, 1'b1);                          // k+1
        issue(OP_STOP, 2'd0, 1'b0);                        // k+2, stop ignored
        step(3);                                           // k+5
        check("R9", "open k+5 stop ignored", 32'(bank_open[0]), 32'h1);
        step(1);
        check("R9", "open k+6", 32'(bank_open[0]), 32'h0);
        step(1);
        check("R9", "act_ok k+7", 32'(act_ok[0]), 32'h0);
        step(1);
        check("R9", "act_ok k+8", 32'(act_ok[0]), 32'h1);
        step(4);
    endtask

    task automatic t_illegal;
        issue(OP_RD, 2'd1, 1'b0);
        check("R11", "read idle flagged", 32'(cmd_illegal), 32'h1);
        check("R11", "read idle no open", 32'(bank_open), 32'h0);
        issue(OP_ACT, 2'd1, 1'b0);                         // a+1
        check("R11", "flag cleared", 32'(cmd_illegal), 32'h0);
        issue(OP_ACT, 2'd1, 1'b0);                         // a+2
        check("R11", "second activate flagged", 32'(cmd_illegal), 32'h1);
        step(1);                                           // a+3
        check("R11", "timer not restarted", 32'(col_ok[1]), 32'h1);
        check("R11", "flag one cycle", 32'(cmd_illegal), 32'h0);
        issue(OP_WR, 2'd2, 1'b0);                          // a+4
        check("R11", "write idle flagged", 32'(cmd_illegal), 32'h1);
        check("R11", "write idle no open", 32'(bank_open), 32'h2);
        step(2);
        issue(OP_PRE, 2'd1, 1'b0);
        step(4);
    endtask

    task automatic t_select_all;
        issue(OP_ACT, 2'b10, 1'b0);                        // a+1
        check("R10", "code 10 is bit 2", 32'(bank_open), 32'h4);
        step(1);
        issue(OP_ACT, 2'b01, 1'b0);                        // a+3
        check("R10", "code 01 is bit 1", 32'(bank_open), 32'h6);
        step(5);                                           // a+8
        issue(OP_PRE, 2'd0, 1'b1);                         // p+1
        check("R10", "all closed", 32'(bank_open), 32'h0);
        check("R10", "act_ok after all", 32'(act_ok), 32'h9);
        step(2);                                           // p+3
        check("R10", "act_ok after tRP", 32'(act_ok), 32'hF);
        step(2);
    endtask

    task automatic t_overdue;
        issue(OP_ACT, 2'd0, 1'b0);                         // a+1
        step(P_RASMAX - 2);                                // a+39
        check("R5", "overdue a+39", 32'(ras_overdue), 32'h0);
        step(1);                                           // a+40
        check("R5", "overdue a+40", 32'(ras_overdue), 32'h1);
        issue(OP_PRE, 2'd0, 1'b0);
        check("R5", "overdue cleared", 32'(ras_overdue), 32'h0);
        step(4);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_open_and_close();
        t_write_recovery();
        t_burst_stop();
        t_auto_read();
        t_auto_write();
        t_illegal();
        t_select_all();
        t_overdue();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule